// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block decides when a logic-capture engine triggers and which samples it keeps. Software first loads a table of conditions and actions through a register-write port. After an arm pulse, the block evaluates one captured sample per clock. Each sample arrives as a vector of precomputed event bits with a valid strobe. The block tracks a current sequencer state, and every state owns a prioritised list of if/then clauses. A clause is true when all of the event bits it selects are high. The lowest-numbered true clause in the current state then executes its actions: a state jump, the trigger, storage qualification, a snapshot, set or clear of an output flag, and operations on two internal counter/timers.

Each counter/timer counts either on explicit increment/decrement actions or, once started, on every clock. Each has a programmable limit, and its "limit reached" flag is fed back as an extra event bit. This lets a sequence wait for N occurrences or for a time-out. The action outputs are registered pulses, so they appear in the cycle after the sample that caused them.

Top module: `tseq_core`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` into the entry chosen by `cfg_addr_i` = {kind[1:0], state, clause}. Kind 0 is a clause condition: bits [EV_W-1:0] are the event mask and bit EV_W is the enable. Kind 1 is a clause action. Kind 2 is a counter limit, where clause bit 0 picks the unit. After reset, every clause is disabled.
- R2: The event vector is {unit1 reached, unit0 reached, event_i}. An enabled clause is true when every masked event bit is 1, so an empty mask is always true. Clauses are evaluated only on cycles with `sample_valid_i` high while armed.
- R3: When several clauses of the current state are true, only the lowest-numbered one executes its actions.
- R4: Action bits [ST_W-1:0] hold the goto target and bit ST_W enables the jump. `state_o` shows the new state one cycle after the sample. Without a sample or an arm, the state holds.
- R5: Action bit ST_W+1 is the trigger. The first trigger action gives a one-cycle `trig_o` pulse and sets `triggered_o`. Later trigger actions are ignored until the next arm.
- R6: Storage uses bits ST_W+2 (store), ST_W+3 (don't store), ST_W+4 (open window) and ST_W+5 (close window). For a sample, `store_o` pulses when the winning clause stores. If the winning clause neither stores nor blocks storage, `store_o` pulses when the window is open. Opening and closing the window take effect from the next sample.
- R7: Bit ST_W+6 pulses `snapshot_o`. Bit ST_W+7 sets `signal_o` and bit ST_W+8 clears it, with clear taking priority.
- R8: Unit u takes operations at bits ST_W+9+5u onward, in the order increment, decrement, clear, start, stop. A counter changes only on increment, decrement or clear. It saturates at all-ones going up and holds at zero going down.
- R9: A started unit adds one on every clock, with or without a sample, from the clock after the start. A stop or an arm halts it.
- R10: A unit's reached event is value >= limit. It becomes visible to clause evaluation in the cycle after the update that crosses the limit.
- R11: Before the first arm, samples have no effect. An arm enters state 0 and clears both units, the run flags, `signal_o`, the storage window and the trigger latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2+ST_W+CL_W | Kind, state and clause select |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| arm_i | input | 1 | Re-arm pulse |
| sample_valid_i | input | 1 | Sample strobe |
| event_i | input | NUM_EXT | Recognizer event bits for the sample |
| state_o | output | ST_W | Current sequencer state |
| trig_o | output | 1 | Trigger pulse |
| triggered_o | output | 1 | Trigger latch |
| store_o | output | 1 | Store-this-sample pulse |
| snapshot_o | output | 1 | Snapshot pulse |
| signal_o | output | 1 | Programmable flag |
| unit0_value_o | output | CNT_W | Counter/timer 0 value |
| unit1_value_o | output | CNT_W | Counter/timer 1 value |

## Verification
The assertions assume that configuration writes do not overlap live sampling. They also assume that an arm pulse is never combined with a sample the caller expects to be evaluated, because arm always wins. The stimulus loads every table entry before the first arm. It drives `arm_i` only on cycles with `sample_valid_i` low, and it changes inputs only on the falling clock edge. Counter saturation is reached with a narrow counter width so that the all-ones boundary is reachable within a short run.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    // Flag positions inside an action word, relative to the goto target field
    localparam int F_GOTO      = 0;
    localparam int F_TRIG      = 1;
    localparam int F_STORE     = 2;
    localparam int F_NOSTORE   = 3;
    localparam int F_WIN_OPEN  = 4;
    localparam int F_WIN_CLOSE = 5;
    localparam int F_SNAP      = 6;
    localparam int F_SIG_SET   = 7;
    localparam int F_SIG_CLR   = 8;
    localparam int F_UNIT_BASE = 9;

    localparam int NUM_UNITS   = 2;
    localparam int UNIT_OPS    = 5;
    localparam int U_INC       = 0;
    localparam int U_DEC       = 1;
    localparam int U_CLR       = 2;
    localparam int U_RUN       = 3;
    localparam int U_HALT      = 4;

    localparam int NUM_FLAGS   = F_UNIT_BASE + NUM_UNITS * UNIT_OPS;

    typedef struct packed {
        logic inc;
        logic dec;
        logic clr;
        logic run;
        logic halt;
    } unit_op_t;

    typedef enum logic [1:0] {
        CFG_COND  = 2'd0,
        CFG_ACT   = 2'd1,
        CFG_LIMIT = 2'd2
    } cfg_kind_e;

endpackage

// File: rtl/tseq_clause_pick.sv
module tseq_clause_pick #(
    parameter int NUM_CLAUSES = 16,
    parameter int EV_W        = 18,
    localparam int CL_W       = $clog2(NUM_CLAUSES),
    localparam int ENT_W      = EV_W + 1
) (
    input  logic [NUM_CLAUSES*ENT_W-1:0] conds_i,
    input  logic [EV_W-1:0]              events_i,
    output logic                         hit_o,
    output logic [CL_W-1:0]              idx_o
);

    logic [ENT_W-1:0] ent;

    // Scan from the top so the lowest true clause is the last one kept
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        ent   = '0;
        for (int c = NUM_CLAUSES - 1; c >= 0; c--) begin
            ent = conds_i[c*ENT_W +: ENT_W];
            if (ent[EV_W] && ((events_i & ent[EV_W-1:0]) == ent[EV_W-1:0])) begin
                hit_o = 1'b1;
                idx_o = CL_W'(c);
            end
        end
    end

endmodule

// File: rtl/tseq_ct_unit.sv
module tseq_ct_unit
    import tseq_pkg::*;
#(
    parameter int CNT_W = 51
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  unit_op_t         op_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] value_o,
    output logic             reached_o
);

    localparam logic [CNT_W-1:0] VMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             running;
    } unit_t;

    unit_t u_d, u_q;
    logic  up, dn;

    always_comb begin
        u_d = u_q;
        up  = op_i.inc | u_q.running;
        dn  = op_i.dec;
        if (clear_i) begin
            u_d.value   = '0;
            u_d.running = 1'b0;
        end else begin
            if (op_i.halt)     u_d.running = 1'b0;
            else if (op_i.run) u_d.running = 1'b1;
            if (op_i.clr) begin
                u_d.value = '0;
            end else if (up && !dn && u_q.value != VMAX) begin
                u_d.value = u_q.value + 1'b1;
            end else if (dn && !up && u_q.value != '0) begin
                u_d.value = u_q.value - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) u_q <= '0;
        else         u_q <= u_d;
    end

    assign value_o   = u_q.value;
    assign reached_o = (u_q.value >= limit_i);

    assert_sat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (u_q.value == VMAX && !clear_i && !op_i.clr && !op_i.dec) |=> (u_q.value == VMAX));

    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !op_i.clr && !op_i.inc && !op_i.dec && !u_q.running) |=> $stable(u_q.value));

    assert_run_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (u_q.running && !clear_i && !op_i.clr && !op_i.dec && u_q.value != VMAX)
        |=> (u_q.value == CNT_W'($past(u_q.value) + 1'b1)));

endmodule

// File: rtl/tseq_core.sv
module tseq_core
    import tseq_pkg::*;
#(
    parameter int NUM_STATES  = 16,
    parameter int NUM_CLAUSES = 16,
    parameter int NUM_EXT     = 16,
    parameter int CNT_W       = 51,
    parameter int CFG_W       = 64,
    localparam int ST_W       = $clog2(NUM_STATES),
    localparam int CL_W       = $clog2(NUM_CLAUSES),
    localparam int AW         = 2 + ST_W + CL_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic               arm_i,
    input  logic               sample_valid_i,
    input  logic [NUM_EXT-1:0] event_i,
    output logic [ST_W-1:0]    state_o,
    output logic               trig_o,
    output logic               triggered_o,
    output logic               store_o,
    output logic               snapshot_o,
    output logic               signal_o,
    output logic [CNT_W-1:0]   unit0_value_o,
    output logic [CNT_W-1:0]   unit1_value_o
);

    localparam int EV_W  = NUM_EXT + NUM_UNITS;
    localparam int ENT_W = EV_W + 1;
    localparam int ACT_W = ST_W + NUM_FLAGS;

    // Configuration tables
    logic [ENT_W-1:0] cond_q  [NUM_STATES][NUM_CLAUSES];
    logic [ACT_W-1:0] act_q   [NUM_STATES][NUM_CLAUSES];
    logic [CNT_W-1:0] limit_q [NUM_UNITS];

    cfg_kind_e        cfg_kind;
    logic [ST_W-1:0]  cfg_st;
    logic [CL_W-1:0]  cfg_cl;

    assign cfg_kind = cfg_kind_e'(cfg_addr_i[AW-1 -: 2]);
    assign cfg_st   = cfg_addr_i[CL_W +: ST_W];
    assign cfg_cl   = cfg_addr_i[CL_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < NUM_STATES; s++)
                for (int c = 0; c < NUM_CLAUSES; c++)
                    cond_q[s][c] <= '0;
            for (int u = 0; u < NUM_UNITS; u++)
                limit_q[u] <= '0;
        end else if (cfg_we_i) begin
            case (cfg_kind)
                CFG_COND:  cond_q[cfg_st][cfg_cl] <= cfg_wdata_i[ENT_W-1:0];
                CFG_LIMIT: limit_q[cfg_cl[0]]     <= cfg_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (cfg_we_i && cfg_kind == CFG_ACT)
            act_q[cfg_st][cfg_cl] <= cfg_wdata_i[ACT_W-1:0];
    end

    // Sequencer state
    typedef struct packed {
        logic            armed;
        logic [ST_W-1:0] state;
        logic            triggered;
        logic            trig;
        logic            store;
        logic            snap;
        logic            sig;
        logic            win;
    } seq_t;

    seq_t s_d, s_q;

    logic [EV_W-1:0]              events;
    logic [NUM_UNITS-1:0]         reached;
    logic [CNT_W-1:0]             unit_val [NUM_UNITS];
    logic [NUM_CLAUSES*ENT_W-1:0] row;
    logic                         hit;
    logic [CL_W-1:0]              hit_idx;
    logic [ACT_W-1:0]             act;
    logic [NUM_FLAGS-1:0]         fl;
    logic                         fire;

    assign events = {reached, event_i};

    always_comb begin
        for (int c = 0; c < NUM_CLAUSES; c++)
            row[c*ENT_W +: ENT_W] = cond_q[s_q.state][c];
    end

    tseq_clause_pick #(
        .NUM_CLAUSES (NUM_CLAUSES),
        .EV_W        (EV_W)
    ) u_pick (
        .conds_i  (row),
        .events_i (events),
        .hit_o    (hit),
        .idx_o    (hit_idx)
    );

    assign act  = act_q[s_q.state][hit_idx];
    assign fl   = act[ACT_W-1:ST_W];
    assign fire = sample_valid_i && s_q.armed && !arm_i && hit;

    always_comb begin
        s_d       = s_q;
        s_d.trig  = 1'b0;
        s_d.store = 1'b0;
        s_d.snap  = 1'b0;
        if (arm_i) begin
            s_d.armed     = 1'b1;
            s_d.state     = '0;
            s_d.triggered = 1'b0;
            s_d.sig       = 1'b0;
            s_d.win       = 1'b0;
        end else if (sample_valid_i && s_q.armed) begin
            s_d.store = s_q.win;
            if (hit) begin
                if (fl[F_STORE])        s_d.store = 1'b1;
                else if (fl[F_NOSTORE]) s_d.store = 1'b0;
                if (fl[F_GOTO])         s_d.state = act[ST_W-1:0];
                if (fl[F_TRIG] && !s_q.triggered) begin
                    s_d.trig      = 1'b1;
                    s_d.triggered = 1'b1;
                end
                s_d.snap = fl[F_SNAP];
                if (fl[F_SIG_CLR])      s_d.sig = 1'b0;
                else if (fl[F_SIG_SET]) s_d.sig = 1'b1;
                if (fl[F_WIN_CLOSE])    s_d.win = 1'b0;
                else if (fl[F_WIN_OPEN]) s_d.win = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // Counter/timer units
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_op_t op;
        always_comb begin
            op      = '0;
            op.inc  = fire & fl[F_UNIT_BASE + u*UNIT_OPS + U_INC];
            op.dec  = fire & fl[F_UNIT_BASE + u*UNIT_OPS + U_DEC];
            op.clr  = fire & fl[F_UNIT_BASE + u*UNIT_OPS + U_CLR];
            op.run  = fire & fl[F_UNIT_BASE + u*UNIT_OPS + U_RUN];
            op.halt = fire & fl[F_UNIT_BASE + u*UNIT_OPS + U_HALT];
        end

        tseq_ct_unit #(
            .CNT_W (CNT_W)
        ) u_ct (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .clear_i   (arm_i),
            .op_i      (op),
            .limit_i   (limit_q[u]),
            .value_o   (unit_val[u]),
            .reached_o (reached[u])
        );
    end

    assign state_o       = s_q.state;
    assign trig_o        = s_q.trig;
    assign triggered_o   = s_q.triggered;
    assign store_o       = s_q.store;
    assign snapshot_o    = s_q.snap;
    assign signal_o      = s_q.sig;
    assign unit0_value_o = unit_val[0];
    assign unit1_value_o = unit_val[1];

    assert_state_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_i && !sample_valid_i) |=> $stable(state_o));

    assert_trig_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (triggered_o && !arm_i) |=> !trig_o);

    assert_arm_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (state_o == '0 && !signal_o && !triggered_o && unit0_value_o == '0));

    assert_pulse_needs_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sample_valid_i || arm_i) |=> (!store_o && !snapshot_o && !trig_o));

endmodule

// File: tb/tseq_core_bench.sv
module tseq_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 6;
    localparam int VMAX       = (1 << CW) - 1;

    // Action word bits (R4..R8 encodings with a 4-bit goto field)
    localparam logic [63:0] A_GOTO  = 64'h1 << 4;
    localparam logic [63:0] A_TRIG  = 64'h1 << 5;
    localparam logic [63:0] A_STORE = 64'h1 << 6;
    localparam logic [63:0] A_NOST  = 64'h1 << 7;
    localparam logic [63:0] A_OPEN  = 64'h1 << 8;
    localparam logic [63:0] A_CLOSE = 64'h1 << 9;
    localparam logic [63:0] A_SNAP  = 64'h1 << 10;
    localparam logic [63:0] A_SSET  = 64'h1 << 11;
    localparam logic [63:0] A_SCLR  = 64'h1 << 12;
    localparam logic [63:0] U0_INC  = 64'h1 << 13;
    localparam logic [63:0] U0_DEC  = 64'h1 << 14;
    localparam logic [63:0] U0_CLR  = 64'h1 << 15;
    localparam logic [63:0] U1_CLR  = 64'h1 << 20;
    localparam logic [63:0] U1_RUN  = 64'h1 << 21;
    localparam logic [63:0] U1_HALT = 64'h1 << 22;
    localparam logic [63:0] C_EN    = 64'h1 << 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        arm = 1'b0;
    logic        valid = 1'b0;
    logic [15:0] ev = '0;
    logic [3:0]  state;
    logic        trig, trgd, store, snap, sig;
    logic [CW-1:0] c0, c1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    st;
        bit    tr, sto, sn, sg, trd;
        int    c0, c1;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tseq_core #(
        .CNT_W (CW)
    ) u_tseq_core (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cfg_we_i       (cfg_we),
        .cfg_addr_i     (cfg_addr),
        .cfg_wdata_i    (cfg_wdata),
        .arm_i          (arm),
        .sample_valid_i (valid),
        .event_i        (ev),
        .state_o        (state),
        .trig_o         (trig),
        .triggered_o    (trgd),
        .store_o        (store),
        .snapshot_o     (snap),
        .signal_o       (sig),
        .unit0_value_o  (c0),
        .unit1_value_o  (c1)
    );

    task automatic cfg_wr(input int kind, input int st, input int cl, input logic [63:0] d);
        @(negedge clk);
        valid     = 1'b0;
        arm       = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = {2'(kind), 4'(st), 4'(cl)};
        cfg_wdata = d;
    endtask

    task automatic step(input string tag, input bit v, input bit a, input logic [15:0] e,
                        input int st, input bit tr, input bit sto, input bit sn,
                        input bit sg, input bit trd, input int x0, input int x1);
        exp_t it;
        @(negedge clk);
        cfg_we = 1'b0;
        valid  = v;
        arm    = a;
        ev     = e;
        it.tag = tag; it.st = st; it.tr = tr; it.sto = sto; it.sn = sn;
        it.sg = sg; it.trd = trd; it.c0 = x0; it.c1 = x1;
        sb.push_back(it);
    endtask

    // Monitor: compares each registered result just after the edge it belongs to
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (int'(state) != it.st || trig != it.tr || store != it.sto || snap != it.sn ||
                    sig != it.sg || trgd != it.trd || int'(c0) != it.c0 || int'(c1) != it.c1) begin
                    failures++;
                    $display("FAIL %s: actual st=%0d tr=%0b sto=%0b sn=%0b sg=%0b trd=%0b c0=%0d c1=%0d expected st=%0d tr=%0b sto=%0b sn=%0b sg=%0b trd=%0b c0=%0d c1=%0d",
                             it.tag, state, trig, store, snap, sig, trgd, c0, c1,
                             it.st, it.tr, it.sto, it.sn, it.sg, it.trd, it.c0, it.c1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (state != 0 || trig || trgd || sig || store || c0 != 0 || c1 != 0) begin
            failures++;
            $display("FAIL R11 reset: actual st=%0d trd=%0b sg=%0b c0=%0d expected st=0 trd=0 sg=0 c0=0",
                     state, trgd, sig, c0);
        end

        // R1 configuration load
        cfg_wr(0, 0, 0, C_EN | 64'h1);       cfg_wr(1, 0, 0, A_GOTO | 64'd1 | A_STORE);
        cfg_wr(0, 0, 1, C_EN | 64'h2);       cfg_wr(1, 0, 1, A_GOTO | 64'd2 | A_SSET);
        cfg_wr(0, 0, 2, C_EN | 64'h80);      cfg_wr(1, 0, 2, U1_CLR | U1_HALT | A_OPEN);
        cfg_wr(0, 0, 3, C_EN | 64'h100);     cfg_wr(1, 0, 3, A_NOST);
        cfg_wr(0, 0, 4, C_EN | 64'h200);     cfg_wr(1, 0, 4, A_CLOSE);
        cfg_wr(0, 0, 15, C_EN);              cfg_wr(1, 0, 15, U0_INC);
        cfg_wr(0, 1, 0, C_EN | 64'h4);       cfg_wr(1, 1, 0, A_GOTO | 64'd3 | A_TRIG);
        cfg_wr(0, 1, 1, C_EN | 64'h8);       cfg_wr(1, 1, 1, U1_RUN);
        cfg_wr(0, 1, 2, 64'h0);              cfg_wr(1, 1, 2, A_GOTO | 64'd5 | A_TRIG);
        cfg_wr(0, 2, 0, C_EN | 64'h10);      cfg_wr(1, 2, 0, U0_DEC);
        cfg_wr(0, 2, 1, C_EN | 64'h20);      cfg_wr(1, 2, 1, A_GOTO | 64'd0 | U0_CLR);
        cfg_wr(0, 3, 0, C_EN | 64'h4);       cfg_wr(1, 3, 0, A_TRIG | A_SNAP);
        cfg_wr(0, 3, 1, C_EN | (64'h1 << 16)); cfg_wr(1, 3, 1, A_SCLR | A_GOTO | 64'd0);
        cfg_wr(0, 3, 2, C_EN | 64'h40);      cfg_wr(1, 3, 2, U0_INC);
        cfg_wr(2, 0, 0, 64'd3);
        cfg_wr(2, 0, 1, 64'(VMAX));

        //    tag          v  a  ev        st tr so sn sg td c0 c1
        step("R11 unarmed",1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11 arm",    0, 1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R2 anything",1, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8 inc",     1, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 2, 0);
        step("R8 inc",     1, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 3, 0);
        step("R1/R4 goto", 1, 0, 16'h0002, 2, 0, 0, 0, 1, 0, 3, 0);
        step("R8 dec",     1, 0, 16'h0010, 2, 0, 0, 0, 1, 0, 2, 0);
        step("R3 prio",    1, 0, 16'h0030, 2, 0, 0, 0, 1, 0, 1, 0);
        step("R4 goto0",   1, 0, 16'h0020, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R2 novalid", 0, 0, 16'h0001, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R3 prio",    1, 0, 16'h0003, 1, 0, 1, 0, 1, 0, 0, 0);
        step("R9 start",   1, 0, 16'h0008, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R9 run",     0, 0, 16'h0000, 1, 0, 0, 0, 1, 0, 0, 1);
        step("R5 trig",    1, 0, 16'h0004, 3, 1, 0, 0, 1, 1, 0, 2);
        step("R5/R7 snap", 1, 0, 16'h0004, 3, 0, 0, 1, 1, 1, 0, 3);
        step("R10 below",  1, 0, 16'h0000, 3, 0, 0, 0, 1, 1, 0, 4);
        step("R8 inc",     1, 0, 16'h0040, 3, 0, 0, 0, 1, 1, 1, 5);
        step("R8 inc",     1, 0, 16'h0040, 3, 0, 0, 0, 1, 1, 2, 6);
        step("R10 same",   1, 0, 16'h0040, 3, 0, 0, 0, 1, 1, 3, 7);
        step("R10/R7 clr", 1, 0, 16'h0000, 0, 0, 0, 0, 0, 1, 3, 8);
        for (int i = 1; i <= 62; i++) begin
            step("R8/R9 sat", 1, 0, 16'h0000, 0, 0, 0, 0, 0, 1,
                 (3 + i > VMAX) ? VMAX : 3 + i, (8 + i > VMAX) ? VMAX : 8 + i);
        end
        step("R9 stop",    1, 0, 16'h0080, 0, 0, 0, 0, 0, 1, VMAX, 0);
        step("R6 window",  1, 0, 16'h0000, 0, 0, 1, 0, 0, 1, VMAX, 0);
        step("R6 nostore", 1, 0, 16'h0100, 0, 0, 0, 0, 0, 1, VMAX, 0);
        step("R6 close",   1, 0, 16'h0200, 0, 0, 1, 0, 0, 1, VMAX, 0);
        step("R6 closed",  1, 0, 16'h0000, 0, 0, 0, 0, 0, 1, VMAX, 0);
        step("R6 idle",    0, 0, 16'h0000, 0, 0, 0, 0, 0, 1, VMAX, 0);
        step("R11 rearm",  0, 1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11 after",  1, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R4 goto2",   1, 0, 16'h0002, 2, 0, 0, 0, 1, 0, 1, 0);
        step("R8 dec",     1, 0, 16'h0010, 2, 0, 0, 0, 1, 0, 0, 0);
        step("R8 zero",    1, 0, 16'h0010, 2, 0, 0, 0, 1, 0, 0, 0);
        step("R4 back",    1, 0, 16'h0020, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R6 store",   1, 0, 16'h0001, 1, 0, 1, 0, 1, 0, 0, 0);
        step("R5 retrig",  1, 0, 16'h0004, 3, 1, 0, 0, 1, 1, 0, 0);
        step("R5 latched", 0, 0, 16'h0000, 3, 0, 0, 0, 1, 1, 0, 0);

        @(negedge clk);
        valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule